// File: doc/BRIEF.md
# Add/Subtract and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two operands of `WIDTH` bits, 32 by default, and a 2-bit operation select. It returns one of four results: the bitwise AND, the bitwise OR, the sum, or the difference of the two operands. It also returns three flags: carry-out, signed overflow and zero. It is meant to sit in the execute stage of a simple processor datapath and has no clock and no state.

Addition and subtraction use a single ripple chain of full-adder cells. Operand B enters the chain through a row of XOR gates. These gates are driven by one subtract control, and the same control is the carry-in of the lowest cell. Subtraction is therefore computed as A + ~B + 1, and addition as A + B with a zero carry-in, where the lowest cell acts as a half adder. Signed overflow is taken from the two carries at the top cell, not from the carry-out alone.

The operands and the result are single-word values with no transfer protocol. There is no valid/ready handshake and no back-pressure: the outputs follow the inputs within the same cycle.

Top module: `alu_core`

## Requirements
- R1: With `op_i` = 2'b00, `result_o` is `a_i & b_i`.
- R2: With `op_i` = 2'b01, `result_o` is `a_i | b_i`.
- R3: With `op_i` = 2'b10, `result_o` is `(a_i + b_i) mod 2^WIDTH`, and `carry_o` is bit WIDTH of the unsigned sum.
- R4: With `op_i` = 2'b11, `result_o` is `(a_i - b_i) mod 2^WIDTH`, and `carry_o` is 1 exactly when `a_i >= b_i` taken as unsigned numbers, meaning no borrow.
- R5: For add, `ovf_o` is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it. For subtract, `ovf_o` is 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of `a_i`.
- R6: `zero_o` is 1 exactly when `result_o` is all zeros, for every operation.
- R7: For the two logic operations (`op_i` 2'b00 and 2'b01), `carry_o` and `ovf_o` are both 0.
- R8: Boundary cases at WIDTH 32:
  - 0x7FFFFFFF + 1 gives 0x80000000 with overflow 1 and carry 0.
  - 0x80000000 - 1 gives 0x7FFFFFFF with overflow 1 and carry 1.
  - All-zero operands under AND give zero 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand; inverted on its way into the chain when subtracting |
| op_i | input | 2 | Operation select: 00 AND, 01 OR, 10 ADD, 11 SUB |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top cell for add and subtract; 0 for logic operations |
| ovf_o | output | 1 | Signed overflow for add and subtract; 0 for logic operations |
| zero_o | output | 1 | High when `result_o` is all zeros |

## Verification
The block has no state, so a fault appears at the ports in the same evaluation as the operands that expose it. A broken carry link between two cells shows as a wrong result only for operand pairs whose carry propagates across that position. An exhaustive sweep over a 4-bit instance covers every such propagation pattern. A faulty XOR row or carry-in shows as a difference that is off by one or off by B, and the ±1 boundary cases at full width expose a flipped overflow or carry rule at once.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    ALU_AND = 2'b00,
    ALU_OR  = 2'b01,
    ALU_ADD = 2'b10,
    ALU_SUB = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic p;
  assign p    = x_i ^ y_i;
  assign s_o  = p ^ ci_i;
  assign co_o = (x_i & y_i) | (ci_i & p);
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             cmsb_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_cond;
  assign b_cond = b_i ^ {WIDTH{sub_i}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic ci;
    logic co;
    if (i == 0) begin : g_lsb
      assign ci = sub_i;
    end else begin : g_link
      assign ci = g_bit[i-1].co;
    end
    alu_fa_cell u_cell (
      .x_i (a_i[i]),
      .y_i (b_cond[i]),
      .ci_i(ci),
      .s_o (sum_o[i]),
      .co_o(co)
    );
  end

  assign cout_o = g_bit[MSB].co;
  assign cmsb_o = g_bit[MSB].ci;
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_or_i,
  output logic [WIDTH-1:0] y_o
);
  assign y_o = sel_or_i ? (a_i | b_i) : (a_i & b_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  alu_op_e          op;
  logic             is_sub;
  logic             is_arith;
  logic [WIDTH-1:0] arith_y;
  logic [WIDTH-1:0] logic_y;
  logic             c_out;
  logic             c_msb;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == ALU_SUB);
  assign is_arith = (op == ALU_ADD) || (op == ALU_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (arith_y),
    .cout_o(c_out),
    .cmsb_o(c_msb)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i     (a_i),
    .b_i     (b_i),
    .sel_or_i(op == ALU_OR),
    .y_o     (logic_y)
  );

  assign result_o = is_arith ? arith_y : logic_y;
  assign carry_o  = is_arith & c_out;
  assign ovf_o    = is_arith & (c_out ^ c_msb);
  assign zero_o   = ~|result_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  localparam int MSB = WIDTH - 1;
  logic known;
  assign known = !$isunknown({a_i, b_i, op_i, result_o, carry_o, ovf_o, zero_o});

  always_comb begin
    if (known) begin
      // R1
      and_subset_chk: assert (op_i != 2'b00 || (result_o & ~a_i & ~b_i) == '0 && (result_o & ~a_i) == '0);
      // R2
      or_superset_chk: assert (op_i != 2'b01 || (result_o & a_i) == a_i);
      // R3
      add_identity_chk: assert (op_i != 2'b10 || a_i != '0 || (result_o == b_i && !carry_o));
      // R4
      sub_equal_chk: assert (op_i != 2'b11 || a_i != b_i || (zero_o && carry_o && !ovf_o));
      // R5
      add_ovf_sign_chk: assert (op_i != 2'b10 || !ovf_o || (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]));
      // R6
      zero_flag_chk: assert (!zero_o || result_o == '0);
      // R7
      logic_flags_chk: assert (op_i[1] || (!carry_o && !ovf_o));
    end
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .result_o(result_o),
  .carry_o(carry_o), .ovf_o(ovf_o), .zero_o(zero_o)
);

// File: tb/test_alu_core.sv
module test_alu_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [31:0] a, b, r;
  logic [1:0]  op;
  logic        c, v, z;
  logic [3:0]  a4, b4, r4;
  logic [1:0]  op4;
  logic        c4, v4, z4;

  alu_core #(.WIDTH(32)) i_alu_core (
    .a_i(a), .b_i(b), .op_i(op), .result_o(r),
    .carry_o(c), .ovf_o(v), .zero_o(z)
  );

  alu_core #(.WIDTH(4)) i_alu_core_w4 (
    .a_i(a4), .b_i(b4), .op_i(op4), .result_o(r4),
    .carry_o(c4), .ovf_o(v4), .zero_o(z4)
  );

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Expected values from the requirement text, computed at 33 bits.
  task automatic run32(input logic [31:0] ta, input logic [31:0] tb_v,
                       input logic [1:0] top, input string ctag);
    logic [32:0] wide;
    logic [31:0] er;
    logic        ec, ev;
    a = ta; b = tb_v; op = top;
    #2;
    ec = 1'b0; ev = 1'b0;
    case (top)
      2'b00: er = ta & tb_v;
      2'b01: er = ta | tb_v;
      2'b10: begin
        wide = {1'b0, ta} + {1'b0, tb_v};
        er = wide[31:0]; ec = wide[32];
        ev = (ta[31] == tb_v[31]) && (er[31] != ta[31]);
      end
      default: begin
        er = ta - tb_v; ec = (ta >= tb_v);
        ev = (ta[31] != tb_v[31]) && (er[31] != ta[31]);
      end
    endcase
    check((ctag != "") ? ctag : op_tag(top), "result", r, er);
    check(top[1] ? op_tag(top) : "R7", "carry", {31'b0, c}, {31'b0, ec});
    check(top[1] ? "R5" : "R7", "overflow", {31'b0, v}, {31'b0, ev});
    check("R6", "zero", {31'b0, z}, {31'b0, er == 32'b0});
  endtask

  task automatic run4(input logic [3:0] ta, input logic [3:0] tb_v, input logic [1:0] top);
    int ia, ib, ir;
    logic [3:0] er;
    logic       ec, ev;
    a4 = ta; b4 = tb_v; op4 = top;
    #2;
    ia = int'(ta); ib = int'(tb_v);
    ec = 1'b0; ev = 1'b0;
    case (top)
      2'b00: er = ta & tb_v;
      2'b01: er = ta | tb_v;
      2'b10: begin
        ir = ia + ib; er = ir[3:0]; ec = (ir > 15);
        ev = (ta[3] == tb_v[3]) && (er[3] != ta[3]);
      end
      default: begin
        ir = ia - ib; er = ir[3:0]; ec = (ia >= ib);
        ev = (ta[3] != tb_v[3]) && (er[3] != ta[3]);
      end
    endcase
    check(op_tag(top), "w4 result", {28'b0, r4}, {28'b0, er});
    check(top[1] ? op_tag(top) : "R7", "w4 carry", {31'b0, c4}, {31'b0, ec});
    check(top[1] ? "R5" : "R7", "w4 overflow", {31'b0, v4}, {31'b0, ev});
    check("R6", "w4 zero", {31'b0, z4}, {31'b0, er == 4'b0});
  endtask

  initial begin
    a = '0; b = '0; op = 2'b00;
    a4 = '0; b4 = '0; op4 = 2'b00;
    #2;
    // R8: quiescent all-zero inputs under AND
    check("R8", "initial zero", {31'b0, z}, 32'd1);
    check("R8", "initial result", r, 32'd0);

    // R8 corners
    run32(32'h7FFF_FFFF, 32'h0000_0001, 2'b10, "R8");
    run32(32'h8000_0000, 32'h0000_0001, 2'b11, "R8");
    run32(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, "");
    run32(32'h0000_0000, 32'h0000_0001, 2'b11, "");
    run32(32'h8000_0000, 32'h8000_0000, 2'b10, "");
    run32(32'h1234_5678, 32'h1234_5678, 2'b11, "");
    run32(32'h0000_0000, 32'h8000_0000, 2'b11, "");
    run32(32'hA5A5_A5A5, 32'h5A5A_5A5A, 2'b00, "");
    run32(32'hA5A5_A5A5, 32'h5A5A_5A5A, 2'b01, "");

    // Exhaustive 4-bit sweep over every operand pair and operation
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run4(4'(x), 4'(y), 2'(o));

    // Random 32-bit operands
    for (int k = 0; k < 1000; k++)
      run32($urandom, $urandom, 2'($urandom_range(0, 3)), "");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule